// File: doc/BRIEF.md
# Bus Suspend Detector and Asynchronous Wake Unit

This unit sits beside a full-speed serial bus device core and handles the low-power side of the link. It samples the two bus data lines through a synchronizer and times how long the lines stay in the idle (J) state. Once that idle stretch reaches a 3 ms window, it raises a sticky suspend-request flag that software reads and clears. The window is given as a count of system clock cycles, which is worked out from the clock frequency and the window length in microseconds.

Software puts the device into the suspended state by writing a set strobe, and takes it out with a clear strobe. While suspended, the device clock may be stopped. Any non-idle line state then sets a wake flag through a path that needs no clock edge, so the flag can act as a dedicated interrupt that restarts clock generation. When the clock runs again, the flag reaches the clock domain through a two-flop synchronizer. It is cleared only after the synchronized copy has been seen and software has left suspend.

Independently, each start-of-frame indication from the packet engine produces an output pulse of fixed length. This pulse starts on the next clock edge.

Top module: `usb_suspend_wake`

## Requirements
- R1: While reset is held, idle_flag, suspended, wake_async, wake_sync and sof_pulse are all 0.
- R2: The lines are idle when {line_dp,line_dm} = 2'b10 (J). The lines pass through a 2-flop synchronizer. If they turn idle just before clock edge 1 and stay idle, idle_flag is 0 after edge IDLE_CYCLES+1 and 1 after edge IDLE_CYCLES+2. IDLE_CYCLES = (CLK_HZ/1e6)*IDLE_US.
- R3: Any non-idle line state restarts the idle count from zero. This covers K (2'b01), SE0 (2'b00) and SE1 (2'b11).
- R4: idle_flag stays set until sw_idle_clr is sampled high. If the timeout and sw_idle_clr fall on the same edge, the flag is set.
- R5: idle_flag is set at most once per idle stretch. After a clear, it stays 0 until non-idle traffic is followed by a fresh full window.
- R6: suspended becomes 1 on the edge after sw_suspend_set and 0 on the edge after sw_suspend_clr. When both strobes are high, clear wins.
- R7: While suspended is 1, a non-idle line state sets wake_async with no clock edge.
- R8: While suspended is 0, line activity never sets wake_async.
- R9: wake_sync equals wake_async delayed by two clock edges.
- R10: wake_async stays 1 while suspended is 1. It returns to 0 one edge after suspended has fallen while wake_sync is 1.
- R11: A sof_seen sample makes sof_pulse high for SOF_PULSE_CYC cycles, starting on the next edge. A new sof_seen restarts the length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (may be stopped while suspended) |
| rst | input | 1 | Synchronous active-high reset; also clears the wake flag directly |
| line_dp | input | 1 | Raw D+ line level |
| line_dm | input | 1 | Raw D- line level |
| sof_seen | input | 1 | One-cycle strobe: a start-of-frame packet was received |
| sw_suspend_set | input | 1 | Software strobe entering the suspended state |
| sw_suspend_clr | input | 1 | Software strobe leaving the suspended state |
| sw_idle_clr | input | 1 | Software strobe clearing the idle timeout flag |
| idle_flag | output | 1 | Sticky flag: 3 ms of idle lines seen |
| suspended | output | 1 | Device is in the suspended state |
| wake_async | output | 1 | Wake flag set without a clock, for clock restart |
| wake_sync | output | 1 | Wake flag synchronized to clk |
| sof_pulse | output | 1 | Pulse locked to each start-of-frame |

## Verification
Two events can land on the same edge: the idle timeout setting idle_flag and a software clear of that flag. The bench produces this by releasing the lines to J, counting exactly IDLE_CYCLES+1 edges, and then raising sw_idle_clr for the timeout edge. It expects the flag to read 1 afterwards. A cycle-by-cycle bench model of the idle timer also checks the same priority under random line bursts with sparse random clears. A separate directed step stops the clock altogether to show that the wake flag rises with no edge.

// File: rtl/usb_sw_pkg.sv
`timescale 1ns/1ps
package usb_sw_pkg;
  // Line state as {dp, dm}
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_K   = 2'b01,
    LS_J   = 2'b10,
    LS_SE1 = 2'b11
  } line_state_e;

  function automatic logic line_is_idle(input logic [1:0] dpdm);
    return dpdm == LS_J;
  endfunction
endpackage

// File: rtl/usb_sw_sync.sv
`timescale 1ns/1ps
module usb_sw_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/usb_idle_timer.sv
`timescale 1ns/1ps
module usb_idle_timer #(
  parameter int LIMIT = 144000
) (
  input  logic clk,
  input  logic rst,
  input  logic idle_s,
  input  logic clr,
  output logic flag
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_V  = CW'(LIMIT);
  localparam logic [CW-1:0] LAST_V = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;
  logic          hit;

  // fires once per idle stretch: counter saturates at LIMIT
  assign hit = idle_s && (cnt == LAST_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      if (!idle_s)           cnt <= '0;
      else if (cnt != LIM_V) cnt <= cnt + 1'b1;
      flag <= hit | (flag & ~clr);
    end
  end
endmodule

// File: rtl/usb_wake_latch.sv
`timescale 1ns/1ps
module usb_wake_latch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic suspended,
  input  logic line_active,
  output logic wake_async,
  output logic wake_sync
);
  logic trig;
  logic clr_q;
  logic arst;

  assign trig = suspended & line_active;
  assign arst = rst | clr_q;

  // Edge on trig sets the flag: no clk needed
  always_ff @(posedge trig or posedge arst) begin
    if (arst) wake_async <= 1'b0;
    else      wake_async <= 1'b1;
  end

  usb_sw_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (wake_async),
    .q   (wake_sync)
  );

  // Clear once the synced copy is seen and software left suspend
  always_ff @(posedge clk) begin
    if (rst) clr_q <= 1'b0;
    else     clr_q <= wake_sync & ~suspended;
  end
endmodule

// File: rtl/usb_sof_pulser.sv
`timescale 1ns/1ps
module usb_sof_pulser #(
  parameter int PULSE_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic sof_seen,
  output logic pulse
);
  localparam int CW = $clog2(PULSE_CYC + 1);
  localparam logic [CW-1:0] LEN_V = CW'(PULSE_CYC);

  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      left  <= '0;
      pulse <= 1'b0;
    end else if (sof_seen) begin
      left  <= LEN_V;
      pulse <= 1'b1;
    end else begin
      pulse <= (left > CW'(1));
      if (left != '0) left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/usb_suspend_wake.sv
`timescale 1ns/1ps
module usb_suspend_wake #(
  parameter int CLK_HZ        = 48_000_000,
  parameter int IDLE_US       = 3000,
  parameter int SOF_PULSE_CYC = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_dp,
  input  logic line_dm,
  input  logic sof_seen,
  input  logic sw_suspend_set,
  input  logic sw_suspend_clr,
  input  logic sw_idle_clr,
  output logic idle_flag,
  output logic suspended,
  output logic wake_async,
  output logic wake_sync,
  output logic sof_pulse
);
  import usb_sw_pkg::*;

  localparam int IDLE_CYCLES = (CLK_HZ / 1_000_000) * IDLE_US;

  logic [1:0] line_s;
  logic       line_active;

  usb_sw_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(LS_J)) u_line_sync (
    .clk (clk),
    .rst (rst),
    .d   ({line_dp, line_dm}),
    .q   (line_s)
  );

  usb_idle_timer #(.LIMIT(IDLE_CYCLES)) u_idle (
    .clk    (clk),
    .rst    (rst),
    .idle_s (line_is_idle(line_s)),
    .clr    (sw_idle_clr),
    .flag   (idle_flag)
  );

  always_ff @(posedge clk) begin
    if (rst)                 suspended <= 1'b0;
    else if (sw_suspend_clr) suspended <= 1'b0;
    else if (sw_suspend_set) suspended <= 1'b1;
  end

  assign line_active = ~line_is_idle({line_dp, line_dm});

  usb_wake_latch #(.SYNC_STAGES(SYNC_STAGES)) u_wake (
    .clk         (clk),
    .rst         (rst),
    .suspended   (suspended),
    .line_active (line_active),
    .wake_async  (wake_async),
    .wake_sync   (wake_sync)
  );

  usb_sof_pulser #(.PULSE_CYC(SOF_PULSE_CYC)) u_sof (
    .clk      (clk),
    .rst      (rst),
    .sof_seen (sof_seen),
    .pulse    (sof_pulse)
  );
endmodule

// File: rtl/usb_suspend_wake_chk.sv
`timescale 1ns/1ps
module usb_suspend_wake_chk (
  input logic clk,
  input logic rst,
  input logic sof_seen,
  input logic sw_suspend_set,
  input logic sw_suspend_clr,
  input logic sw_idle_clr,
  input logic idle_flag,
  input logic suspended,
  input logic wake_async,
  input logic wake_sync,
  input logic sof_pulse
);
  AST_SOF_STARTS: assert property (@(posedge clk) disable iff (rst)
    sof_seen |=> sof_pulse); // R11

  AST_SUSP_ENTER: assert property (@(posedge clk) disable iff (rst)
    (sw_suspend_set && !sw_suspend_clr) |=> suspended); // R6

  AST_SUSP_LEAVE: assert property (@(posedge clk) disable iff (rst)
    sw_suspend_clr |=> !suspended); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (idle_flag && !sw_idle_clr) |=> idle_flag); // R4

  AST_NO_WAKE_AWAKE: assert property (@(posedge clk) disable iff (rst)
    (!suspended && !wake_async) |=> !wake_async); // R8

  AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (suspended && wake_async) |=> wake_async); // R10

  AST_SYNC_AFTER_ASYNC: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_sync) |-> wake_async); // R9
endmodule

bind usb_suspend_wake usb_suspend_wake_chk u_chk (.*);

// File: tb/tb_usb_suspend_wake.sv
`timescale 1ns/1ps
module tb_usb_suspend_wake;
  localparam int CLK_HZ  = 10_000_000;
  localparam int IDLE_US = 3;
  localparam int PW      = 3;
  localparam int LIM     = (CLK_HZ / 1_000_000) * IDLE_US;

  logic clk = 1'b0, clk_run = 1'b1;
  logic rst = 1'b1, dp = 1'b1, dm = 1'b0, sof = 1'b0;
  logic sset = 1'b0, sclr = 1'b0, iclr = 1'b0;
  logic idle_flag, suspended, wake_async, wake_sync, sof_pulse;

  int checks = 0, errors = 0;
  logic m1 = 1'b1, m2 = 1'b1, mflag = 1'b0;
  int   mcnt = 0;

  always begin
    #2.5;
    if (clk_run) clk = ~clk;
  end

  usb_suspend_wake #(.CLK_HZ(CLK_HZ), .IDLE_US(IDLE_US), .SOF_PULSE_CYC(PW)) dut (
    .clk(clk), .rst(rst), .line_dp(dp), .line_dm(dm), .sof_seen(sof),
    .sw_suspend_set(sset), .sw_suspend_clr(sclr), .sw_idle_clr(iclr),
    .idle_flag(idle_flag), .suspended(suspended), .wake_async(wake_async),
    .wake_sync(wake_sync), .sof_pulse(sof_pulse)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", req, act, exp);
    end
  endtask

  // Idle timer model from R2..R5
  task automatic model_edge();
    logic hit;
    if (rst) begin
      m1 = 1'b1; m2 = 1'b1; mcnt = 0; mflag = 1'b0;
    end else begin
      hit = m2 && (mcnt == LIM - 1);
      if (!m2) mcnt = 0;
      else if (mcnt != LIM) mcnt++;
      mflag = hit | (mflag & ~iclr);
      m2 = m1;
      m1 = dp && !dm;
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R2/R3 idle model", idle_flag, mflag);
  endtask

  task automatic line(input logic [1:0] v);
    dp = v[1]; dm = v[0];
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) step();
    chk("R1 idle_flag", idle_flag, 1'b0);
    chk("R1 suspended", suspended, 1'b0);
    chk("R1 wake_async", wake_async, 1'b0);
    chk("R1 wake_sync", wake_sync, 1'b0);
    chk("R1 sof_pulse", sof_pulse, 1'b0);
    rst = 1'b0;

    // R2 exact timeout edge
    line(2'b01); repeat (3) step();
    line(2'b10);
    repeat (LIM + 1) step();
    chk("R2 before timeout", idle_flag, 1'b0);
    step();
    chk("R2 at timeout", idle_flag, 1'b1);

    // R4 sticky then clear, R5 no re-set
    repeat (5) step();
    chk("R4 sticky", idle_flag, 1'b1);
    iclr = 1'b1; step(); iclr = 1'b0;
    chk("R4 cleared", idle_flag, 1'b0);
    repeat (LIM + 5) step();
    chk("R5 no second set", idle_flag, 1'b0);

    // R3 restart on SE0 and SE1 mid-window
    line(2'b01); repeat (2) step();
    line(2'b10); repeat (LIM - 5) step();
    line(2'b11); step();
    line(2'b10); repeat (LIM - 4) step();
    line(2'b00); step();
    line(2'b10);
    repeat (LIM + 1) step();
    chk("R3 restarted count", idle_flag, 1'b0);
    step();
    chk("R3 full window", idle_flag, 1'b1);
    iclr = 1'b1; step(); iclr = 1'b0;

    // R4 coincidence: timeout and clear on same edge
    line(2'b01); repeat (3) step();
    line(2'b10);
    repeat (LIM + 1) step();
    iclr = 1'b1; step(); iclr = 1'b0;
    chk("R4 set wins over clear", idle_flag, 1'b1);
    iclr = 1'b1; step(); iclr = 1'b0;

    // R11 start-of-frame pulse
    sof = 1'b1; step(); sof = 1'b0;
    chk("R11 pulse c1", sof_pulse, 1'b1);
    step(); chk("R11 pulse c2", sof_pulse, 1'b1);
    step(); chk("R11 pulse c3", sof_pulse, 1'b1);
    step(); chk("R11 pulse end", sof_pulse, 1'b0);
    sof = 1'b1; step(); sof = 1'b0; step();
    sof = 1'b1; step(); sof = 1'b0;
    chk("R11 restart c1", sof_pulse, 1'b1);
    step(); chk("R11 restart c2", sof_pulse, 1'b1);
    step(); chk("R11 restart c3", sof_pulse, 1'b1);
    step(); chk("R11 restart end", sof_pulse, 1'b0);

    // R8 no wake while awake
    line(2'b01); repeat (3) step();
    chk("R8 wake_async", wake_async, 1'b0);
    chk("R8 wake_sync", wake_sync, 1'b0);
    line(2'b10);

    // R6 suspend strobes
    sset = 1'b1; sclr = 1'b1; step(); sset = 1'b0; sclr = 1'b0;
    chk("R6 clear wins", suspended, 1'b0);
    sset = 1'b1; step(); sset = 1'b0;
    chk("R6 entered", suspended, 1'b1);
    step();
    chk("R8 idle lines no wake", wake_async, 1'b0);

    // R7 wake with clock stopped
    clk_run = 1'b0;
    #20;
    line(2'b01);
    #20;
    chk("R7 wake without clock", wake_async, 1'b1);
    chk("R9 not yet synced", wake_sync, 1'b0);
    line(2'b10);
    #1;
    clk_run = 1'b1;
    step(); chk("R9 sync edge1", wake_sync, 1'b0);
    step(); chk("R9 sync edge2", wake_sync, 1'b1);

    // R10 clear sequence
    repeat (4) step();
    chk("R10 held while suspended", wake_async, 1'b1);
    chk("R6 still suspended", suspended, 1'b1);
    sclr = 1'b1; step(); sclr = 1'b0;
    chk("R6 left suspend", suspended, 1'b0);
    chk("R10 pending", wake_async, 1'b1);
    step();
    chk("R10 cleared", wake_async, 1'b0);
    repeat (3) step();
    chk("R9 sync cleared", wake_sync, 1'b0);

    // Random line bursts with sparse clears against the model
    for (int seg = 0; seg < 60; seg++) begin
      int idle_len;
      int busy_len;
      idle_len = 1 + int'($urandom % 45);
      busy_len = 1 + int'($urandom % 3);
      line(2'b10);
      for (int k = 0; k < idle_len; k++) begin
        iclr = ($urandom % 20) == 0;
        sof  = ($urandom % 8) == 0;
        step();
      end
      for (int k = 0; k < busy_len; k++) begin
        logic [1:0] v;
        v = 2'($urandom % 4);
        if (v == 2'b10) v = 2'b01;
        line(v);
        iclr = ($urandom % 20) == 0;
        step();
      end
      iclr = 1'b0; sof = 1'b0;
    end
    chk("R8 random stays awake", wake_async, 1'b0);

    finish_run();
  end
endmodule